// File: doc/BRIEF.md
# Memory Ordering Issue Gate

The gate sits between a core's in-order memory-operation queue and the memory system. Each cycle it looks at the operation at the head of the queue. It decides at once whether that operation may go out, given the operations already in flight and the ordering discipline in force. Operations that go to memory take one of a small number of tracking slots. A slot is freed only when memory returns an acknowledgement naming it.

Five ordering disciplines can be chosen at run time:

- Fully serial (sequential).
- Loads bypass stores, without forwarding.
- Loads bypass stores, with own-store forwarding.
- Partial store order.
- Weak/release.

The gate also understands five fence kinds:

- A draining full barrier.
- A draining write barrier.
- A non-blocking store barrier that only holds back later stores.
- An acquire, which blocks everything behind it until it completes.
- A release, which waits for everything ahead of it.

A change of discipline takes effect only once nothing is in flight.

Top module: `ord_issue_gate`

## Requirements
- R1: Operation codes are 0 load, 1 store, 2 full barrier, 3 write barrier, 4 store barrier, 5 acquire, 6 release, 7 treated as full barrier. Mode codes are 0 serial, 1 load-bypass strict, 2 load-bypass forwarding, 3 partial store, 4 weak; codes 5 to 7 act as serial. The head operation is granted combinationally (`issue_o`, with `stall_o` = valid and not granted). Loads, stores, acquires and releases occupy the lowest-numbered free slot, reported on `issue_slot_o`. A slot stays busy until `ack_valid_i` names it; an acknowledgement naming an idle slot changes nothing.
- R2: At most N_SLOTS (default 4) operations are in flight. With all slots busy, a slot-taking operation stalls.
- R3: In mode 0, no load, store, acquire or release issues while any slot is busy.
- R4: In mode 1, a load issues while stores to other addresses are in flight, but never while a load or acquire is in flight. A store waits until nothing is in flight. A load to the address of an in-flight store waits for that store's acknowledgement.
- R5: In modes 2, 3 and 4, a load whose address matches in-flight stores but no in-flight load is granted with `fwd_o`=1. It takes no slot and needs no acknowledgement. Its load-ordering condition still applies.
- R6: In mode 3, a store may issue while stores to other addresses are in flight, but not while a load or acquire is in flight.
- R7: In mode 4, loads and stores issue while operations to other addresses of either kind are in flight.
- R8: In every mode, a load (other than a forwarded one), store, acquire or release stalls while any in-flight slot holds the same address.
- R9: A full barrier is granted only when no slot is busy, and takes no slot.
- R10: A write barrier is granted only when no store or release is in flight. It takes no slot.
- R11: A store barrier is granted at once. Afterwards, stores stall until every store in flight at the barrier has been acknowledged; loads are not held back.
- R12: While an acquire is in flight, nothing issues.
- R13: A release issues only when no slot is busy. Later operations may issue while it is in flight.
- R14: The mode input is taken only while no slot is busy. If it differs from the held mode while slots are busy, every operation stalls until they drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Requested ordering discipline |
| op_valid_i | input | 1 | Head operation present |
| op_type_i | input | 3 | Head operation code |
| op_addr_i | input | ADDR_W | Head operation address |
| ack_valid_i | input | 1 | Memory completion strobe |
| ack_slot_i | input | SLOT_W | Slot being completed |
| issue_o | output | 1 | Head operation granted this cycle |
| issue_slot_o | output | SLOT_W | Slot taken by the granted operation |
| fwd_o | output | 1 | Granted load served from own pending store |
| stall_o | output | 1 | Head operation held back |

## Verification
Each discipline is exercised with the same kind of mixed sequence: a store in flight followed by a load elsewhere, a load to the store's address, a second store, and a load behind a load. The grant/stall pattern then separates serial, strict bypass, forwarding bypass, partial store and weak behaviour. Fence sequences put a load or store behind each barrier kind with stores and loads outstanding. This tells a draining barrier from the non-blocking store barrier, and an acquire from a release. Corner cases covered are a full table, slot reuse order, a stray acknowledgement to an idle slot, and a mode change requested with work in flight.

// File: rtl/ord_gate_pkg.sv
package ord_gate_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_FULL  = 3'd2,
    OP_WBAR  = 3'd3,
    OP_SBAR  = 3'd4,
    OP_ACQ   = 3'd5,
    OP_REL   = 3'd6,
    OP_RSVD  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    MD_SEQ  = 3'd0,
    MD_WR   = 3'd1,
    MD_TSO  = 3'd2,
    MD_PSO  = 3'd3,
    MD_WEAK = 3'd4
  } mode_e;

  typedef struct packed {
    logic any_valid;
    logic any_ld;
    logic any_st;
    logic any_acq;
    logic any_wf;
    logic full;
    logic hit_ld;
    logic hit_st;
  } haz_t;

  function automatic mode_e decode_mode(input logic [2:0] raw);
    return (raw > 3'd4) ? MD_SEQ : mode_e'(raw);
  endfunction

endpackage

// File: rtl/ord_slot_table.sv
module ord_slot_table #(
  parameter int N_SLOTS = 4,
  parameter int ADDR_W  = 16,
  localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           alloc_i,
  input  logic                           alloc_ld_i,
  input  logic                           alloc_st_i,
  input  logic                           alloc_acq_i,
  input  logic [ADDR_W-1:0]              alloc_addr_i,
  input  logic                           sbar_i,
  input  logic                           ack_i,
  input  logic [SLOT_W-1:0]              ack_slot_i,
  output logic [N_SLOTS-1:0]             valid_o,
  output logic [N_SLOTS-1:0]             ld_o,
  output logic [N_SLOTS-1:0]             st_o,
  output logic [N_SLOTS-1:0]             acq_o,
  output logic [N_SLOTS-1:0]             wf_o,
  output logic [N_SLOTS-1:0][ADDR_W-1:0] addr_o,
  output logic [SLOT_W-1:0]              free_idx_o,
  output logic                           full_o
);

  logic [N_SLOTS-1:0]             valid_q, ld_q, st_q, acq_q, wf_q;
  logic [N_SLOTS-1:0][ADDR_W-1:0] addr_q;

  // lowest free slot wins
  always_comb begin
    free_idx_o = '0;
    for (int k = N_SLOTS - 1; k >= 0; k--) begin
      if (!valid_q[k]) free_idx_o = SLOT_W'(k);
    end
  end

  assign full_o  = &valid_q;
  assign valid_o = valid_q;
  assign ld_o    = ld_q;
  assign st_o    = st_q;
  assign acq_o   = acq_q;
  assign wf_o    = wf_q;
  assign addr_o  = addr_q;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic hit_ack, hit_alloc;
    assign hit_ack   = ack_i && (ack_slot_i == SLOT_W'(i)) && valid_q[i];
    assign hit_alloc = alloc_i && (free_idx_o == SLOT_W'(i)) && !valid_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        ld_q[i]    <= 1'b0;
        st_q[i]    <= 1'b0;
        acq_q[i]   <= 1'b0;
        wf_q[i]    <= 1'b0;
        addr_q[i]  <= '0;
      end else if (hit_ack) begin
        valid_q[i] <= 1'b0;
        wf_q[i]    <= 1'b0;
      end else if (hit_alloc) begin
        valid_q[i] <= 1'b1;
        ld_q[i]    <= alloc_ld_i;
        st_q[i]    <= alloc_st_i;
        acq_q[i]   <= alloc_acq_i;
        wf_q[i]    <= 1'b0;
        addr_q[i]  <= alloc_addr_i;
      end else if (sbar_i && valid_q[i] && st_q[i]) begin
        wf_q[i]    <= 1'b1;
      end
    end

    AST_HELD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_q[i] && !(ack_i && ack_slot_i == SLOT_W'(i))) |=> valid_q[i]); // R1
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o); // R2

endmodule

// File: rtl/ord_hazard.sv
module ord_hazard
  import ord_gate_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int ADDR_W  = 16
) (
  input  logic [N_SLOTS-1:0]             valid_i,
  input  logic [N_SLOTS-1:0]             ld_i,
  input  logic [N_SLOTS-1:0]             st_i,
  input  logic [N_SLOTS-1:0]             acq_i,
  input  logic [N_SLOTS-1:0]             wf_i,
  input  logic [N_SLOTS-1:0][ADDR_W-1:0] addr_i,
  input  logic                           full_i,
  input  logic [ADDR_W-1:0]              op_addr_i,
  output haz_t                           haz_o
);

  logic [N_SLOTS-1:0] match;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_cmp
    assign match[i] = valid_i[i] && (addr_i[i] == op_addr_i);
  end

  always_comb begin
    haz_o.any_valid = |valid_i;
    haz_o.any_ld    = |(valid_i & ld_i);
    haz_o.any_st    = |(valid_i & st_i);
    haz_o.any_acq   = |(valid_i & acq_i);
    haz_o.any_wf    = |(valid_i & wf_i);
    haz_o.full      = full_i;
    haz_o.hit_ld    = |(match & ld_i);
    haz_o.hit_st    = |(match & st_i);
  end

endmodule

// File: rtl/ord_rules.sv
module ord_rules
  import ord_gate_pkg::*;
(
  input  mode_e mode_i,
  input  logic  op_valid_i,
  input  op_e   op_i,
  input  haz_t  haz_i,
  input  logic  mode_stall_i,
  output logic  grant_o,
  output logic  take_o,
  output logic  fwd_o,
  output logic  as_ld_o,
  output logic  as_st_o,
  output logic  as_acq_o,
  output logic  sbar_o
);

  logic ld_ord, st_ord, fwd_md, base, hit;

  always_comb begin
    unique case (mode_i)
      MD_WR, MD_TSO: begin
        ld_ord = !haz_i.any_ld;
        st_ord = !haz_i.any_valid;
      end
      MD_PSO: begin
        ld_ord = !haz_i.any_ld;
        st_ord = !haz_i.any_ld && !haz_i.any_wf;
      end
      MD_WEAK: begin
        ld_ord = 1'b1;
        st_ord = !haz_i.any_wf;
      end
      default: begin
        ld_ord = !haz_i.any_valid;
        st_ord = !haz_i.any_valid;
      end
    endcase
  end

  assign fwd_md = (mode_i == MD_TSO) || (mode_i == MD_PSO) || (mode_i == MD_WEAK);
  assign base   = op_valid_i && !haz_i.any_acq && !mode_stall_i;
  assign hit    = haz_i.hit_ld || haz_i.hit_st;

  always_comb begin
    grant_o  = 1'b0;
    take_o   = 1'b0;
    fwd_o    = 1'b0;
    as_ld_o  = 1'b0;
    as_st_o  = 1'b0;
    as_acq_o = 1'b0;
    sbar_o   = 1'b0;
    unique case (op_i)
      OP_LOAD: begin
        if (base && ld_ord) begin
          if (!hit && !haz_i.full) begin
            grant_o = 1'b1;
            take_o  = 1'b1;
            as_ld_o = 1'b1;
          end else if (fwd_md && haz_i.hit_st && !haz_i.hit_ld) begin
            grant_o = 1'b1;
            fwd_o   = 1'b1;
          end
        end
      end
      OP_STORE: begin
        if (base && st_ord && !hit && !haz_i.full) begin
          grant_o = 1'b1;
          take_o  = 1'b1;
          as_st_o = 1'b1;
        end
      end
      OP_ACQ: begin
        if (base && ld_ord && !hit && !haz_i.full) begin
          grant_o  = 1'b1;
          take_o   = 1'b1;
          as_ld_o  = 1'b1;
          as_acq_o = 1'b1;
        end
      end
      OP_REL: begin
        if (base && !haz_i.any_valid) begin
          grant_o = 1'b1;
          take_o  = 1'b1;
          as_st_o = 1'b1;
        end
      end
      OP_WBAR: grant_o = base && !haz_i.any_st;
      OP_SBAR: begin
        grant_o = base;
        sbar_o  = base;
      end
      default: grant_o = base && !haz_i.any_valid;
    endcase
  end

endmodule

// File: rtl/ord_issue_gate.sv
module ord_issue_gate
  import ord_gate_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int ADDR_W  = 16,
  localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              op_valid_i,
  input  logic [2:0]        op_type_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic              ack_valid_i,
  input  logic [SLOT_W-1:0] ack_slot_i,
  output logic              issue_o,
  output logic [SLOT_W-1:0] issue_slot_o,
  output logic              fwd_o,
  output logic              stall_o
);

  logic [N_SLOTS-1:0]             valid, ld, st, acq, wf;
  logic [N_SLOTS-1:0][ADDR_W-1:0] addr;
  logic [SLOT_W-1:0]              free_idx;
  logic                           full;
  haz_t                           haz;

  logic [2:0] mode_q, mode_eff;
  mode_e      mode;
  logic       mode_stall;
  op_e        op;
  logic       grant, take, as_ld, as_st, as_acq, sbar;

  // mode is only re-sampled while nothing is in flight
  assign mode_eff   = haz.any_valid ? mode_q : mode_i;
  assign mode_stall = haz.any_valid && (mode_i != mode_q);
  assign mode       = decode_mode(mode_eff);
  assign op         = op_e'(op_type_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 3'd0;
    else         mode_q <= mode_eff;
  end

  ord_slot_table #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W)) u_tab (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (take),
    .alloc_ld_i   (as_ld),
    .alloc_st_i   (as_st),
    .alloc_acq_i  (as_acq),
    .alloc_addr_i (op_addr_i),
    .sbar_i       (sbar),
    .ack_i        (ack_valid_i),
    .ack_slot_i   (ack_slot_i),
    .valid_o      (valid),
    .ld_o         (ld),
    .st_o         (st),
    .acq_o        (acq),
    .wf_o         (wf),
    .addr_o       (addr),
    .free_idx_o   (free_idx),
    .full_o       (full)
  );

  ord_hazard #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W)) u_haz (
    .valid_i   (valid),
    .ld_i      (ld),
    .st_i      (st),
    .acq_i     (acq),
    .wf_i      (wf),
    .addr_i    (addr),
    .full_i    (full),
    .op_addr_i (op_addr_i),
    .haz_o     (haz)
  );

  ord_rules u_rule (
    .mode_i       (mode),
    .op_valid_i   (op_valid_i),
    .op_i         (op),
    .haz_i        (haz),
    .mode_stall_i (mode_stall),
    .grant_o      (grant),
    .take_o       (take),
    .fwd_o        (fwd_o),
    .as_ld_o      (as_ld),
    .as_st_o      (as_st),
    .as_acq_o     (as_acq),
    .sbar_o       (sbar)
  );

  assign issue_o      = grant;
  assign issue_slot_o = take ? free_idx : '0;
  assign stall_o      = op_valid_i && !grant;

  AST_SEQ_SERIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mode == MD_SEQ) |-> !(|valid)); // R3
  AST_ACQ_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(valid & acq)) |-> !issue_o); // R12
  AST_MODE_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|valid) && mode_i != mode_q) |-> !issue_o); // R14
  AST_FWD_RELAXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> (op == OP_LOAD && mode != MD_SEQ && mode != MD_WR)); // R5
  AST_REL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && op == OP_REL) |-> !(|valid)); // R13
  AST_SLOT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !ack_valid_i) |=> valid[$past(free_idx)]); // R1

endmodule

// File: tb/sim_ord_issue_gate.sv
module sim_ord_issue_gate;

  localparam int AW = 16;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode = 3'd0;
  logic          op_valid = 1'b0;
  logic [2:0]    op_type = 3'd0;
  logic [AW-1:0] op_addr = '0;
  logic          ack_valid = 1'b0;
  logic [SW-1:0] ack_slot = '0;
  logic          issue, fwd, stall;
  logic [SW-1:0] islot;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [2:0] LD = 3'd0, ST = 3'd1, FULLB = 3'd2, WB = 3'd3,
                         SB = 3'd4, ACQ = 3'd5, REL = 3'd6;

  always #4 clk = ~clk;

  ord_issue_gate #(.N_SLOTS(4), .ADDR_W(AW)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_i       (mode),
    .op_valid_i   (op_valid),
    .op_type_i    (op_type),
    .op_addr_i    (op_addr),
    .ack_valid_i  (ack_valid),
    .ack_slot_i   (ack_slot),
    .issue_o      (issue),
    .issue_slot_o (islot),
    .fwd_o        (fwd),
    .stall_o      (stall)
  );

  task automatic check(input bit ok, input string req, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // exp_slot < 0: slot not compared
  task automatic op(input logic [2:0] t, input logic [AW-1:0] a, input bit e_iss,
                    input bit e_fwd, input int e_slot, input string req);
    @(negedge clk);
    op_valid = 1'b1; op_type = t; op_addr = a;
    #1;
    check(issue == e_iss && stall == !e_iss && fwd == e_fwd &&
          (e_slot < 0 || !e_iss || islot == SW'(e_slot)), req,
          $sformatf("iss=%0b stall=%0b fwd=%0b slot=%0d", issue, stall, fwd, islot),
          $sformatf("iss=%0b stall=%0b fwd=%0b slot=%0d", e_iss, !e_iss, e_fwd, e_slot));
    @(posedge clk); #1;
    op_valid = 1'b0;
  endtask

  task automatic ack(input int s);
    @(negedge clk);
    ack_valid = 1'b1; ack_slot = SW'(s);
    @(posedge clk); #1;
    ack_valid = 1'b0;
  endtask

  task automatic t_reset;
    #2;
    check(issue == 1'b0 && stall == 1'b0 && fwd == 1'b0, "R1",
          $sformatf("iss=%0b stall=%0b", issue, stall), "iss=0 stall=0");
  endtask

  task automatic t_seq;
    mode = 3'd0;
    op(LD, 16'h10, 1, 0, 0, "R3");
    op(LD, 16'h20, 0, 0, -1, "R3");
    ack(3);                                   // idle slot, ignored (R1)
    op(LD, 16'h20, 0, 0, -1, "R1 stray ack");
    ack(0);
    op(LD, 16'h20, 1, 0, 0, "R1 slot reuse");
    ack(0);
    op(ST, 16'h30, 1, 0, 0, "R3");
    ack(0);
  endtask

  task automatic t_wr;
    mode = 3'd1;
    op(ST, 16'h10, 1, 0, 0, "R4");
    op(LD, 16'h20, 1, 0, 1, "R4 load bypass");
    op(LD, 16'h10, 0, 0, -1, "R4 own store no fwd");
    op(ST, 16'h40, 0, 0, -1, "R4 store waits");
    op(LD, 16'h50, 0, 0, -1, "R4 load order");
    ack(1); ack(0);
  endtask

  task automatic t_tso;
    mode = 3'd2;
    op(ST, 16'h10, 1, 0, 0, "R5");
    op(LD, 16'h10, 1, 1, -1, "R5 forward");
    op(LD, 16'h20, 1, 0, 1, "R5 fwd took no slot");
    ack(0); ack(1);
  endtask

  task automatic t_pso;
    mode = 3'd3;
    op(ST, 16'h10, 1, 0, 0, "R6");
    op(ST, 16'h20, 1, 0, 1, "R6 store pass");
    op(LD, 16'h30, 1, 0, 2, "R6");
    op(ST, 16'h40, 0, 0, -1, "R6 load ahead");
    ack(2);
    op(ST, 16'h40, 1, 0, 2, "R6");
    op(ST, 16'h10, 0, 0, -1, "R8 same addr");
    ack(0); ack(1); ack(2);
  endtask

  task automatic t_weak;
    mode = 3'd4;
    op(LD, 16'h10, 1, 0, 0, "R7");
    op(LD, 16'h20, 1, 0, 1, "R7 load pass load");
    op(ST, 16'h30, 1, 0, 2, "R7 store pass load");
    op(ST, 16'h10, 0, 0, -1, "R8 store vs load");
    op(LD, 16'h10, 0, 0, -1, "R8 load vs load");
    op(ST, 16'h40, 1, 0, 3, "R7");
    op(LD, 16'h50, 0, 0, -1, "R2 full");
    ack(1);
    op(LD, 16'h50, 1, 0, 1, "R2 freed");
    ack(0); ack(1); ack(2); ack(3);
  endtask

  task automatic t_full;
    mode = 3'd4;
    op(ST, 16'h10, 1, 0, 0, "R9");
    op(FULLB, 16'h0, 0, 0, -1, "R9 waits");
    ack(0);
    op(FULLB, 16'h0, 1, 0, -1, "R9 granted");
    op(LD, 16'h20, 1, 0, 0, "R9 no slot");
    ack(0);
  endtask

  task automatic t_wbar;
    mode = 3'd4;
    op(LD, 16'h10, 1, 0, 0, "R10");
    op(ST, 16'h20, 1, 0, 1, "R10");
    op(WB, 16'h0, 0, 0, -1, "R10 store pending");
    ack(1);
    op(WB, 16'h0, 1, 0, -1, "R10 load ok");
    ack(0);
  endtask

  task automatic t_sbar;
    mode = 3'd4;
    op(ST, 16'h10, 1, 0, 0, "R11");
    op(SB, 16'h0, 1, 0, -1, "R11 immediate");
    op(ST, 16'h20, 0, 0, -1, "R11 store held");
    op(LD, 16'h30, 1, 0, 1, "R11 load free");
    ack(0);
    op(ST, 16'h20, 1, 0, 0, "R11 released");
    ack(0); ack(1);
  endtask

  task automatic t_acq;
    mode = 3'd4;
    op(ACQ, 16'h10, 1, 0, 0, "R12");
    op(LD, 16'h20, 0, 0, -1, "R12 load held");
    op(ST, 16'h30, 0, 0, -1, "R12 store held");
    ack(0);
    op(LD, 16'h20, 1, 0, 0, "R12 after ack");
    ack(0);
  endtask

  task automatic t_rel;
    mode = 3'd4;
    op(ST, 16'h10, 1, 0, 0, "R13");
    op(REL, 16'h20, 0, 0, -1, "R13 waits");
    ack(0);
    op(REL, 16'h20, 1, 0, 0, "R13 granted");
    op(LD, 16'h30, 1, 0, 1, "R13 overtake");
    ack(0); ack(1);
  endtask

  task automatic t_mode;
    mode = 3'd4;
    op(ST, 16'h10, 1, 0, 0, "R14");
    mode = 3'd0;
    op(LD, 16'h20, 0, 0, -1, "R14 drain stall");
    ack(0);
    op(LD, 16'h20, 1, 0, 0, "R14 new mode");
    op(LD, 16'h30, 0, 0, -1, "R14 serial now");
    ack(0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_seq();
    t_wr();
    t_tso();
    t_pso();
    t_weak();
    t_full();
    t_wbar();
    t_sbar();
    t_acq();
    t_rel();
    t_mode();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule